// File: doc/BRIEF.md
# Converter Test-Pattern Capture Checker

This block sits behind the capture path of a high-speed data converter. It checks the sample words that the converter produces while it runs one of its built-in digital test patterns. No analog signal is involved, so any mismatch points at the digital capture logic: clock polarity at the double-data-rate input stage, or a pipeline stage added to one half of the word and not the other.

Two patterns are supported. The first is a fixed word with alternating bits. The second is a slow ramp: an 11-bit code that stays on each value for eight valid samples and then steps up by one.

The checker reports three things:
- whether it has locked onto the stream;
- how many compared samples disagreed;
- which bit group carried the disagreements. Bits at odd positions form one group and bits at even positions form the other, because a skew in the DDR capture shows up as errors confined to one group.

Top module: `adc_pattern_checker`

## Requirements
- R1: After reset, and in the cycle after a sampled `clr`, `err_count` is 0 and `odd_fault`, `even_fault`, `locked` and `pass` are all 0.
- R2: When `mode_ramp` is 0, every valid sample is compared against the word whose bit i is 1 for even i and 0 for odd i (0x555 for 11 bits). Each valid sample that differs adds one to `err_count`.
- R3: When `mode_ramp` is 1 and tracking, the expected code stays on one value for exactly 8 valid samples and then rises by one. Cycles with `smp_valid` low neither advance nor check the ramp.
- R4: The expected ramp code wraps from 2047 to 0 and continues without an error being counted.
- R5: In ramp mode, the first valid sample after a restart is loaded as the reference, and nothing is compared while acquiring. The first later sample whose code differs from the reference starts tracking. From that sample on, the expected code is the reference plus one, held for that sample and seven more. That first differing sample is itself not compared.
- R6: `locked` rises after 16 consecutive compared samples that match. A mismatch before that point restarts the run. Once set, `locked` stays high until `clr` or a change of `mode_ramp`.
- R7: A mismatch in any odd bit position (1, 3, 5, ...) sets `odd_fault`, and a mismatch in any even bit position (0, 2, 4, ...) sets `even_fault`. Both flags are sticky until `clr`.
- R8: `err_count` saturates at 65535 and does not wrap.
- R9: `pass` is high exactly when `locked` is high and neither group flag is set.
- R10: A change of `mode_ramp` drops `locked` and restarts acquisition. It leaves `err_count` and both flags unchanged.
- R11: A sample presented in the same cycle as `clr` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr | input | 1 | Synchronous clear of counter, flags and lock; restarts acquisition |
| mode_ramp | input | 1 | 1 selects the ramp pattern, 0 the alternating-bit word |
| smp_valid | input | 1 | Qualifies `smp_data` in this cycle |
| smp_data | input | 11 | Captured sample word |
| locked | output | 1 | Checker has seen 16 matching samples in a row |
| pass | output | 1 | Locked and no group fault recorded |
| err_count | output | 16 | Saturating count of mismatching samples |
| odd_fault | output | 1 | Sticky: a mismatch touched an odd bit position |
| even_fault | output | 1 | Sticky: a mismatch touched an even bit position |

## Verification
The bench runs a one-sample delay on only the odd bits, and then on only the even bits, across ramp steps. A checker that mixed up the two groups would raise the wrong flag. One that aligned on a stale sample would spread errors into the other group.

It crosses the 2047-to-0 wrap with gaps in `smp_valid`. A design that counted invalid cycles, or failed to wrap, would report errors on a clean ramp. A run with a ninth held sample shows whether the eight-sample hold is exact.

It also probes three other edges:
- lock between the 15th and 16th matching sample;
- `clr` arriving together with a bad sample;
- a mode switch, which must drop lock but keep the counts.

Finally, a long run of bad words drives the counter into saturation, which exposes a counter that wraps.

// File: rtl/apc_pkg.sv
package apc_pkg;

    // Acquisition progress of the ramp reference
    typedef enum logic [1:0] {
        SEEK_IDLE   = 2'd0,
        SEEK_SETTLE = 2'd1,
        SEEK_FOLLOW = 2'd2
    } seek_e;

endpackage

// File: rtl/apc_expect_gen.sv
module apc_expect_gen
    import apc_pkg::*;
#(
    parameter int DATA_W = 11,
    parameter int HOLD   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              mode_ramp,
    input  logic              smp_valid,
    input  logic [DATA_W-1:0] smp_data,
    output logic              cmp_en,
    output logic [DATA_W-1:0] exp_word
);

    localparam int PH_W = $clog2(HOLD + 1);
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(HOLD);
    localparam logic [PH_W-1:0] PH_ONE  = PH_W'(1);

    typedef struct packed {
        seek_e             st;
        logic [DATA_W-1:0] code;
        logic [PH_W-1:0]   phase;
    } gen_s;

    gen_s gen_d, gen_q;

    logic [DATA_W-1:0] alt_word;
    logic [DATA_W-1:0] code_next;
    logic              step_now;

    // Alternating-bit word: ones on even positions
    for (genvar g = 0; g < DATA_W; g++) begin : g_alt
        assign alt_word[g] = ((g % 2) == 0);
    end

    always_comb begin
        gen_d     = gen_q;
        code_next = gen_q.code + 1'b1;
        step_now  = (gen_q.phase == PH_LAST);

        if (mode_ramp) begin
            exp_word = step_now ? code_next : gen_q.code;
            cmp_en   = smp_valid && !restart && (gen_q.st == SEEK_FOLLOW);
        end else begin
            exp_word = alt_word;
            cmp_en   = smp_valid && !restart;
        end

        if (restart) begin
            gen_d.st    = SEEK_IDLE;
            gen_d.phase = '0;
        end else if (smp_valid && mode_ramp) begin
            unique case (gen_q.st)
                SEEK_IDLE: begin
                    gen_d.code  = smp_data;
                    gen_d.phase = PH_ONE;
                    gen_d.st    = SEEK_SETTLE;
                end
                SEEK_SETTLE: begin
                    if (smp_data == gen_q.code) begin
                        if (gen_q.phase != PH_LAST) begin
                            gen_d.phase = gen_q.phase + 1'b1;
                        end
                    end else begin
                        // first change marks the start of a new code
                        gen_d.code  = code_next;
                        gen_d.phase = PH_ONE;
                        gen_d.st    = SEEK_FOLLOW;
                    end
                end
                SEEK_FOLLOW: begin
                    if (step_now) begin
                        gen_d.code  = code_next;
                        gen_d.phase = PH_ONE;
                    end else begin
                        gen_d.phase = gen_q.phase + 1'b1;
                    end
                end
                default: gen_d.st = SEEK_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gen_q <= '{st: SEEK_IDLE, code: '0, phase: '0};
        end else begin
            gen_q <= gen_d;
        end
    end

    // R3, R4: tracked code rises by one (modulo) after the last held sample
    a_r3_ramp_step: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_ramp && !restart && smp_valid && gen_q.st == SEEK_FOLLOW && gen_q.phase == PH_LAST)
        |=> (gen_q.code == DATA_W'($past(gen_q.code) + 1'b1)));

    // R3: code held inside the eight-sample window
    a_r3_ramp_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!restart && gen_q.st == SEEK_FOLLOW && (!smp_valid || gen_q.phase != PH_LAST))
        |=> $stable(gen_q.code));

    // R5: a restart always returns to acquisition
    a_r5_restart_hunt: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (gen_q.st == SEEK_IDLE));

endmodule

// File: rtl/apc_group_cmp.sv
module apc_group_cmp #(
    parameter int DATA_W = 11
) (
    input  logic [DATA_W-1:0] smp_data,
    input  logic [DATA_W-1:0] exp_word,
    output logic              odd_miss,
    output logic              even_miss
);

    logic [DATA_W-1:0] odd_mask;
    logic [DATA_W-1:0] diff;

    for (genvar g = 0; g < DATA_W; g++) begin : g_mask
        assign odd_mask[g] = ((g % 2) == 1);
    end

    always_comb begin
        diff      = smp_data ^ exp_word;
        odd_miss  = |(diff & odd_mask);
        even_miss = |(diff & ~odd_mask);
        // R7: the two groups together cover every bit of the word
        a_r7_groups_cover: assert ((odd_miss || even_miss) == (smp_data != exp_word));
    end

endmodule

// File: rtl/apc_score.sv
module apc_score #(
    parameter int CNT_W  = 16,
    parameter int LOCK_N = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             restart,
    input  logic             cmp_en,
    input  logic             odd_miss,
    input  logic             even_miss,
    output logic [CNT_W-1:0] err_count,
    output logic             odd_fault,
    output logic             even_fault,
    output logic             locked
);

    localparam int RUN_W = $clog2(LOCK_N + 1);
    localparam logic [RUN_W-1:0] RUN_FULL = RUN_W'(LOCK_N);
    localparam logic [CNT_W-1:0] CNT_MAX  = '1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             odd;
        logic             even;
        logic [RUN_W-1:0] run;
        logic             lock;
    } score_s;

    score_s sc_d, sc_q;
    logic   miss;

    always_comb begin
        sc_d = sc_q;
        miss = odd_miss || even_miss;
        if (clr) begin
            sc_d = '0;
        end else if (restart) begin
            sc_d.run  = '0;
            sc_d.lock = 1'b0;
        end else if (cmp_en) begin
            if (miss) begin
                if (sc_q.cnt != CNT_MAX) begin
                    sc_d.cnt = sc_q.cnt + 1'b1;
                end
                sc_d.odd  = sc_q.odd  || odd_miss;
                sc_d.even = sc_q.even || even_miss;
                sc_d.run  = '0;
            end else if (sc_q.run != RUN_FULL) begin
                sc_d.run = sc_q.run + 1'b1;
                if (sc_q.run == RUN_FULL - 1'b1) begin
                    sc_d.lock = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sc_q <= '0;
        end else begin
            sc_q <= sc_d;
        end
    end

    assign err_count  = sc_q.cnt;
    assign odd_fault  = sc_q.odd;
    assign even_fault = sc_q.even;
    assign locked     = sc_q.lock;

    // R8: saturated counter stays put until cleared
    a_r8_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && sc_q.cnt == CNT_MAX) |=> (sc_q.cnt == CNT_MAX));

    // R2: counter moves only on a compared mismatch
    a_r2_cnt_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !(cmp_en && (odd_miss || even_miss))) |=> $stable(sc_q.cnt));

    // R7: group flags are sticky
    a_r7_odd_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (sc_q.odd && !clr) |=> sc_q.odd);
    a_r7_even_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (sc_q.even && !clr) |=> sc_q.even);

    // R1: clear empties all results
    a_r1_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (sc_q.cnt == '0 && !sc_q.odd && !sc_q.even && !sc_q.lock));

    // R6: lock held until clear or restart
    a_r6_lock_held: assert property (@(posedge clk) disable iff (!rst_n)
        (sc_q.lock && !restart) |=> sc_q.lock);

endmodule

// File: rtl/adc_pattern_checker.sv
module adc_pattern_checker #(
    parameter int DATA_W = 11,
    parameter int HOLD   = 8,
    parameter int LOCK_N = 16,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              mode_ramp,
    input  logic              smp_valid,
    input  logic [DATA_W-1:0] smp_data,
    output logic              locked,
    output logic              pass,
    output logic [CNT_W-1:0]  err_count,
    output logic              odd_fault,
    output logic              even_fault
);

    typedef struct packed {
        logic mode;
    } top_s;

    top_s top_d, top_q;

    logic              restart;
    logic              cmp_en;
    logic [DATA_W-1:0] exp_word;
    logic              odd_miss;
    logic              even_miss;

    always_comb begin
        top_d      = top_q;
        top_d.mode = mode_ramp;
        restart    = clr || (mode_ramp != top_q.mode);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            top_q <= '0;
        end else begin
            top_q <= top_d;
        end
    end

    apc_expect_gen #(.DATA_W(DATA_W), .HOLD(HOLD)) u_gen (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart   (restart),
        .mode_ramp (mode_ramp),
        .smp_valid (smp_valid),
        .smp_data  (smp_data),
        .cmp_en    (cmp_en),
        .exp_word  (exp_word)
    );

    apc_group_cmp #(.DATA_W(DATA_W)) u_cmp (
        .smp_data  (smp_data),
        .exp_word  (exp_word),
        .odd_miss  (odd_miss),
        .even_miss (even_miss)
    );

    apc_score #(.CNT_W(CNT_W), .LOCK_N(LOCK_N)) u_score (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (clr),
        .restart    (restart),
        .cmp_en     (cmp_en),
        .odd_miss   (odd_miss),
        .even_miss  (even_miss),
        .err_count  (err_count),
        .odd_fault  (odd_fault),
        .even_fault (even_fault),
        .locked     (locked)
    );

    assign pass = locked && !odd_fault && !even_fault;

    // R10: a mode change drops lock on the next edge
    a_r10_mode_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_ramp != top_q.mode) |=> !locked);

    // R10: a mode change alone leaves the counter untouched
    a_r10_cnt_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && mode_ramp != top_q.mode) |=> $stable(err_count));

    // R11: a sample arriving with clear is not counted
    a_r11_clr_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && smp_valid) |=> (err_count == '0));

endmodule

// File: tb/adc_pattern_checker_test.sv
module adc_pattern_checker_test;

    localparam int ALT  = 'h555;
    localparam int ODDM = 'h2AA;
    localparam int EVNM = 'h555;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clr = 1'b0;
    logic        mode_ramp = 1'b0;
    logic        smp_valid = 1'b0;
    logic [10:0] smp_data = '0;
    logic        locked, pass, odd_fault, even_fault;
    logic [15:0] err_count;

    int n_checks = 0;
    int n_err = 0;

    // behavioural reference state
    bit m_mode = 0;
    int m_st = 0;     // 0 acquire-first, 1 settle, 2 follow
    int m_code = 0;
    int m_phase = 0;
    int m_run = 0;
    bit m_lock = 0;
    int m_cnt = 0;
    bit m_odd = 0;
    bit m_even = 0;

    always #4 clk = ~clk;

    adc_pattern_checker uut (
        .clk(clk), .rst_n(rst_n), .clr(clr), .mode_ramp(mode_ramp),
        .smp_valid(smp_valid), .smp_data(smp_data), .locked(locked),
        .pass(pass), .err_count(err_count), .odd_fault(odd_fault),
        .even_fault(even_fault)
    );

    task automatic chk(string req, string what, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    endtask

    task automatic model_step(bit c, bit m, bit v, int d);
        bit restart = c || (m != m_mode);
        bit cmp = 0;
        int exp = 0;
        if (!restart && v) begin
            if (!m) begin
                cmp = 1; exp = ALT;
            end else if (m_st == 2) begin
                cmp = 1;
                exp = (m_phase == 8) ? (m_code + 1) % 2048 : m_code;
            end
        end
        if (c) begin
            m_cnt = 0; m_odd = 0; m_even = 0; m_run = 0; m_lock = 0;
        end else if (restart) begin
            m_run = 0; m_lock = 0;
        end else if (cmp) begin
            if (d != exp) begin
                if (m_cnt < 65535) m_cnt++;
                if (((d ^ exp) & ODDM) != 0) m_odd = 1;
                if (((d ^ exp) & EVNM) != 0) m_even = 1;
                m_run = 0;
            end else if (m_run < 16) begin
                m_run++;
                if (m_run == 16) m_lock = 1;
            end
        end
        if (restart) begin
            m_st = 0; m_phase = 0;
        end else if (v && m) begin
            case (m_st)
                0: begin m_code = d; m_phase = 1; m_st = 1; end
                1: begin
                    if (d == m_code) begin
                        if (m_phase < 8) m_phase++;
                    end else begin
                        m_code = (m_code + 1) % 2048; m_phase = 1; m_st = 2;
                    end
                end
                default: begin
                    if (m_phase == 8) begin
                        m_code = (m_code + 1) % 2048; m_phase = 1;
                    end else m_phase++;
                end
            endcase
        end
        m_mode = m;
    endtask

    task automatic compare_all(string req);
        chk(req, "err_count", int'(err_count), m_cnt);
        chk(req, "odd_fault", int'(odd_fault), int'(m_odd));
        chk(req, "even_fault", int'(even_fault), int'(m_even));
        chk(req, "locked", int'(locked), int'(m_lock));
        chk("R9", "pass", int'(pass), int'(m_lock && !m_odd && !m_even));
    endtask

    task automatic cyc(bit c, bit m, bit v, int d, string req);
        clr = c; mode_ramp = m; smp_valid = v; smp_data = d[10:0];
        @(posedge clk);
        model_step(c, m, v, d);
        @(negedge clk);
        compare_all(req);
    endtask

    // grp: 0 clean, 1 odd bits one sample late, 2 even bits one sample late
    task automatic ramp_run(int pos0, int n, int grp, string req);
        int prev = ((pos0 - 1) / 8) % 2048;
        for (int k = 0; k < n; k++) begin
            int code = ((pos0 + k) / 8) % 2048;
            int d = code;
            if (grp == 1) d = (code & ~ODDM & 'h7FF) | (prev & ODDM);
            if (grp == 2) d = (code & ~EVNM & 'h7FF) | (prev & EVNM);
            if (k % 5 == 2) cyc(0, 1, 0, (k * 37) & 'h7FF, req);  // R3 gap
            cyc(0, 1, 1, d, req);
            prev = code;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_err++;
        $display("FAIL watchdog expired actual=running expected=done");
        summary();
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1", "err_count", int'(err_count), 0);
        chk("R1", "locked", int'(locked), 0);
        chk("R1", "pass", int'(pass), 0);
        chk("R1", "faults", int'(odd_fault) + int'(even_fault), 0);

        // R2, R6: alternating word, lock boundary
        for (int i = 0; i < 15; i++) cyc(0, 0, 1, ALT, "R6");
        chk("R6", "locked after 15", int'(locked), 0);
        cyc(0, 0, 1, ALT, "R6");
        chk("R6", "locked after 16", int'(locked), 1);
        for (int i = 0; i < 4; i++) cyc(0, 0, 1, ALT, "R2");

        // R2, R7: odd-bit error in alternating mode, lock held
        for (int i = 0; i < 3; i++) begin
            cyc(0, 0, 1, ALT ^ 2, "R2");
            cyc(0, 0, 0, 0, "R2");
            cyc(0, 0, 1, ALT, "R2");
        end
        chk("R2", "err_count", int'(err_count), 3);
        chk("R7", "odd only", int'(odd_fault) * 2 + int'(even_fault), 2);
        chk("R6", "lock held", int'(locked), 1);
        chk("R9", "pass low", int'(pass), 0);

        // R10: mode change
        cyc(0, 1, 0, 0, "R10");
        cyc(0, 1, 0, 0, "R10");
        chk("R10", "locked dropped", int'(locked), 0);
        chk("R10", "count kept", int'(err_count), 3);

        // R11: clear with a bad sample
        cyc(1, 1, 1, 'h123, "R11");
        chk("R11", "err_count", int'(err_count), 0);
        chk("R1", "flags cleared", int'(odd_fault) + int'(even_fault), 0);

        // R4, R5, R3: clean ramp across wrap with valid gaps
        ramp_run(2044 * 8 + 3, 200, 0, "R4");
        chk("R4", "err_count", int'(err_count), 0);
        chk("R4", "locked", int'(locked), 1);
        chk("R9", "pass", int'(pass), 1);

        // R3, R5: hold must be exactly eight samples
        cyc(1, 1, 0, 0, "R1");
        for (int i = 0; i < 3; i++) cyc(0, 1, 1, 500, "R5");
        for (int i = 0; i < 8; i++) cyc(0, 1, 1, 501, "R5");
        for (int i = 0; i < 9; i++) cyc(0, 1, 1, 502, "R3");
        chk("R3", "ninth held sample", int'(err_count), 1);
        chk("R7", "bit0 is even", int'(even_fault) * 2 + int'(odd_fault), 2);

        // R7: odd bits delayed
        cyc(1, 1, 0, 0, "R1");
        ramp_run(600 * 8 + 2, 400, 1, "R7");
        chk("R7", "odd delay odd_fault", int'(odd_fault), 1);
        chk("R7", "odd delay even_fault", int'(even_fault), 0);

        // R7: even bits delayed
        cyc(1, 1, 0, 0, "R1");
        ramp_run(301 * 8 + 2, 400, 2, "R7");
        chk("R7", "even delay even_fault", int'(even_fault), 1);
        chk("R7", "even delay odd_fault", int'(odd_fault), 0);

        // R8: saturation
        cyc(1, 0, 0, 0, "R1");
        for (int i = 0; i < 65540; i++) cyc(0, 0, 1, 0, "R8");
        chk("R8", "saturated", int'(err_count), 65535);

        summary();
        $finish;
    end

endmodule